// File: doc/BRIEF.md
# Multi-Width Serial Direct Transfer Engine

This block is a serial transfer engine driven entirely by software through two FIFOs. Software writes 21-bit records into a transmit FIFO. Each record holds up to 16 data bits and says four things about itself: whether it is an 8-bit or a 16-bit transfer, whether it uses one, two or four data lanes, whether those lanes are driven, and whether its received result should be kept. The engine pops each record, shifts its data out on a serial clock, and at the same time samples as many bits back in. Unless the record asks otherwise, it places the received value in a receive FIFO for software to read.

Records of any size and lane count may follow one another with no reconfiguration. A command and an address can therefore go out on one lane, or with the lanes driven, and read data can come back on four released lanes. Software marks the command records so that they leave no result behind. The engine refuses to start a record whose result would not fit in the receive FIFO, so nothing received is ever lost. The serial clock rate comes from a fixed divider of the system clock.

The sequencing lives in one state machine with five states. `ST_IDLE` holds chip select high. It goes to `ST_FETCH` when the transmit FIFO is not empty. `ST_FETCH` has three exits:
- It returns to `ST_IDLE` when no record is pending.
- It stays in `ST_FETCH` (the stall) when the next record would push into a full receive FIFO.
- Otherwise it pops and loads the record and goes to `ST_LOW`.

`ST_LOW` is the low half of an SCK period. When its divider count ends, it samples the inputs (the rising edge) and goes to `ST_HIGH`. `ST_HIGH` is the high half. When its count ends, it either shifts out the next bit group (the falling edge) and returns to `ST_LOW`, or, after the last group, goes to `ST_PUSH`. `ST_PUSH` writes the result when that is allowed and goes back to `ST_FETCH`.

Top module: `sdx_engine`

## Requirements
- R1: A record is laid out as data in bits 15:0, lane mode in bits 17:16 (0 single, 1 dual, 2 quad, 3 treated as quad), size in bit 18 (0 is 8-bit, 1 is 16-bit), drive enable in bit 19 and no-push in bit 20. An 8-bit record sends only data bits 7:0, and within each byte the most significant bit goes first.
- R2: A 16-bit record sends data bits 7:0 first and then data bits 15:8.
- R3: Each SCK period carries 1 bit on lane 0 in single mode, 2 bits on lanes 1:0 in dual mode (lane 1 is the more significant), and 4 bits on lanes 3:0 in quad mode (lane 3 is the most significant).
- R4: Input bits are sampled at each SCK rise, from lane 1 in single mode and from lanes 1:0 or 3:0 in dual and quad mode, in the same bit order as the output. An 8-bit result sits in bits 7:0 of the receive entry with bits 15:8 zero. In a 16-bit result, the first byte received is bits 7:0.
- R5: Lane outputs change only while SCK is low (on falling edges). The first bit group is present before the first rising edge. SCK is low whenever chip select is high.
- R6: In single mode the drive enable is ignored and the lane enables are 0001 during the record.
- R7: In dual mode the lane enables are 0011 when the record's drive enable is 1 and 0000 when it is 0. In quad mode they are 1111 or 0000.
- R8: A record with no-push set shifts normally but leaves no receive FIFO entry.
- R9: A record that would push is not started while the receive FIFO is full. It starts after software reads an entry, and every received value arrives in order.
- R10: A no-push record is not stalled by a full receive FIFO.
- R11: After reset cs_n is 1, SCK is 0, all lane enables are 0, busy is 0 and both FIFOs are empty. Busy is 1 and cs_n is 0 from the time a record is pending until the transmit FIFO is empty and the last record has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Write a record into the transmit FIFO (ignored when full) |
| tx_wr_data | input | 21 | Record to write |
| tx_full | output | 1 | Transmit FIFO is full |
| rx_rd_en | input | 1 | Pop the head of the receive FIFO (ignored when empty) |
| rx_rd_data | output | 16 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| lane_out | output | 4 | Output values of the four data lanes |
| lane_oe | output | 4 | Output enables of the four data lanes |
| lane_in | input | 4 | Input values of the four data lanes |
| busy | output | 1 | A record is pending or in progress |

## Verification
The bench builds the engine with a two-cycle SCK half period, a four-entry transmit FIFO and a two-entry receive FIFO. That small receive depth lets the stall, the resume and the no-push bypass be reached with three records. Every combination of lane mode, size, drive enable and no-push is swept. The bench loops the lanes back inverted and lane-shifted, so the expected transmit stream and receive value follow from the data word alone.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    localparam int REC_W  = 21;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_PUSH
    } sdx_state_e;

    typedef struct packed {
        logic        nopush;
        logic        drive;
        logic        wide;
        logic [1:0]  lanes;
        logic [15:0] data;
    } sdx_rec_t;

endpackage

// File: rtl/sdx_fifo.sv
module sdx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

endmodule

// File: rtl/sdx_shifter.sv
module sdx_shifter
    import sdx_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  sdx_rec_t    rec,
    input  logic        tx_empty,
    input  logic        rx_full,
    input  logic [3:0]  lane_in,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [15:0] rx_data,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  lane_out,
    output logic [3:0]  lane_oe,
    output logic        busy
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    sdx_state_e    state;
    logic [CW-1:0] div_cnt;
    logic          half_end;
    logic [15:0]   tx_sh, rx_sh;
    logic [4:0]    steps_left;
    logic [1:0]    cur_lanes;
    logic          cur_drive, cur_wide, cur_nopush;
    logic          can_start;
    logic [1:0]    shamt;

    assign half_end  = (div_cnt == CW'(SCK_HALF - 1));
    assign can_start = !tx_empty && (rec.nopush || !rx_full);
    assign shamt     = (rec.lanes == 2'd0) ? 2'd0 : (rec.lanes == 2'd1) ? 2'd1 : 2'd2;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            div_cnt    <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            steps_left <= '0;
            cur_lanes  <= '0;
            cur_drive  <= 1'b0;
            cur_wide   <= 1'b0;
            cur_nopush <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!tx_empty) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (tx_empty) begin
                        state <= ST_IDLE;
                    end else if (can_start) begin
                        tx_sh      <= rec.wide ? {rec.data[7:0], rec.data[15:8]}
                                               : {rec.data[7:0], 8'h00};
                        rx_sh      <= '0;
                        steps_left <= (rec.wide ? 5'd16 : 5'd8) >> shamt;
                        cur_lanes  <= rec.lanes;
                        cur_drive  <= rec.drive;
                        cur_wide   <= rec.wide;
                        cur_nopush <= rec.nopush;
                        div_cnt    <= '0;
                        state      <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (half_end) begin
                        div_cnt    <= '0;
                        steps_left <= steps_left - 1'b1;
                        unique case (cur_lanes)
                            2'd0:    rx_sh <= {rx_sh[14:0], lane_in[1]};
                            2'd1:    rx_sh <= {rx_sh[13:0], lane_in[1:0]};
                            default: rx_sh <= {rx_sh[11:0], lane_in};
                        endcase
                        state <= ST_HIGH;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        if (steps_left == '0) begin
                            state <= ST_PUSH;
                        end else begin
                            unique case (cur_lanes)
                                2'd0:    tx_sh <= {tx_sh[14:0], 1'b0};
                                2'd1:    tx_sh <= {tx_sh[13:0], 2'b00};
                                default: tx_sh <= {tx_sh[11:0], 4'h0};
                            endcase
                            state <= ST_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_PUSH: state <= ST_FETCH;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sck      = 1'b0;
        cs_n     = 1'b0;
        lane_out = 4'h0;
        lane_oe  = 4'h0;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        unique case (state)
            ST_IDLE:  cs_n = 1'b1;
            ST_FETCH: tx_pop = can_start;
            ST_LOW, ST_HIGH: begin
                sck = (state == ST_HIGH);
                unique case (cur_lanes)
                    2'd0: begin
                        lane_out = {3'b000, tx_sh[15]};
                        lane_oe  = 4'b0001;
                    end
                    2'd1: begin
                        lane_out = {2'b00, tx_sh[15:14]};
                        lane_oe  = cur_drive ? 4'b0011 : 4'b0000;
                    end
                    default: begin
                        lane_out = tx_sh[15:12];
                        lane_oe  = cur_drive ? 4'b1111 : 4'b0000;
                    end
                endcase
            end
            ST_PUSH:  rx_push = !cur_nopush;
            default:  cs_n = 1'b1;
        endcase
    end

    assign busy    = !cs_n;
    assign rx_data = cur_wide ? {rx_sh[7:0], rx_sh[15:8]} : {8'h00, rx_sh[7:0]};

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(lane_out));

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R11
    pop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (!cs_n && !sck));

endmodule

// File: rtl/sdx_engine.sv
module sdx_engine
    import sdx_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr_en,
    input  logic [REC_W-1:0]  tx_wr_data,
    output logic              tx_full,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              rx_empty,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        lane_out,
    output logic [3:0]        lane_oe,
    input  logic [3:0]        lane_in,
    output logic              busy
);
    logic [REC_W-1:0]  tx_head;
    logic              tx_empty, tx_pop;
    logic              rx_full, rx_push;
    logic [DATA_W-1:0] rx_data;
    sdx_rec_t          rec;

    assign rec = sdx_rec_t'(tx_head);

    sdx_fifo #(.W(REC_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr_en), .wr_data(tx_wr_data),
        .rd_en(tx_pop), .rd_data(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    sdx_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_push), .wr_data(rx_data),
        .rd_en(rx_rd_en), .rd_data(rx_rd_data),
        .full(rx_full), .empty(rx_empty)
    );

    sdx_shifter #(.SCK_HALF(SCK_HALF)) i_shifter (
        .clk(clk), .rst_n(rst_n),
        .rec(rec), .tx_empty(tx_empty), .rx_full(rx_full),
        .lane_in(lane_in),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
        .sck(sck), .cs_n(cs_n),
        .lane_out(lane_out), .lane_oe(lane_oe), .busy(busy)
    );

    // R8
    nopush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !rx_push) |=> rx_empty);

endmodule

// File: tb/test_sdx_engine.sv
module test_sdx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr_en = 1'b0;
    logic [20:0] tx_wr_data = '0;
    logic        tx_full;
    logic        rx_rd_en = 1'b0;
    logic [15:0] rx_rd_data;
    logic        rx_empty;
    logic        sck, cs_n, busy;
    logic [3:0]  lane_out, lane_oe, lane_in;

    int errors = 0;
    int checks = 0;

    logic [1:0]  cur_w = 2'd0;
    logic        cur_oe = 1'b0;
    logic [15:0] cap = '0;
    int          cap_n = 0;
    int          oe_err = 0;

    always #2.5 clk = ~clk;

    sdx_engine #(.SCK_HALF(2), .TX_DEPTH(4), .RX_DEPTH(2)) i_sdx_engine (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .sck(sck), .cs_n(cs_n),
        .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in),
        .busy(busy)
    );

    // inverted loopback; single mode returns on lane 1 only
    assign lane_in = (cur_w == 2'd0) ? {2'b00, ~lane_out[0], 1'b0} : ~lane_out;

    always @(posedge sck) begin
        logic [3:0] exp_oe;
        case (cur_w)
            2'd0: begin cap = {cap[14:0], lane_out[0]};   cap_n += 1; exp_oe = 4'b0001; end
            2'd1: begin cap = {cap[13:0], lane_out[1:0]}; cap_n += 2; exp_oe = cur_oe ? 4'b0011 : 4'b0000; end
            default: begin cap = {cap[11:0], lane_out};   cap_n += 4; exp_oe = cur_oe ? 4'b1111 : 4'b0000; end
        endcase
        if (lane_oe != exp_oe) oe_err += 1;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks += 1;
        if (!ok) begin
            errors += 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_rec(input logic np, input logic oe, input logic wd,
                            input logic [1:0] iw, input logic [15:0] d);
        @(negedge clk);
        tx_wr_en   = 1'b1;
        tx_wr_data = {np, oe, wd, iw, d};
        @(negedge clk);
        tx_wr_en   = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk);
        rx_rd_en = 1'b1;
        @(negedge clk);
        rx_rd_en = 1'b0;
    endtask

    task automatic run_record(input logic np, input logic oe, input logic wd,
                              input logic [1:0] iw, input logic [15:0] d);
        logic [15:0] exp_cap, exp_rx;
        cur_w = iw; cur_oe = oe; cap = '0; cap_n = 0; oe_err = 0;
        push_rec(np, oe, wd, iw, d);
        wait (busy == 1'b1);
        @(negedge clk);
        chk(cs_n == 1'b0, "R11 cs_n low while pending", {31'd0, cs_n}, 32'd0);
        wait (busy == 1'b0);
        @(negedge clk);
        exp_cap = wd ? {d[7:0], d[15:8]} : {8'h00, d[7:0]};
        exp_rx  = wd ? ~d : {8'h00, ~d[7:0]};
        chk(cap == exp_cap && cap_n == (wd ? 16 : 8), "R1 R2 R3 tx stream",
            {cap_n[15:0], cap}, {(wd ? 16'd16 : 16'd8), exp_cap});
        if (iw == 2'd0) chk(oe_err == 0, "R6 single lane enables", oe_err, 0);
        else            chk(oe_err == 0, "R7 dual/quad lane enables", oe_err, 0);
        if (np) begin
            chk(rx_empty == 1'b1, "R8 no-push leaves no entry", {31'd0, rx_empty}, 32'd1);
        end else begin
            chk(!rx_empty && rx_rd_data == exp_rx, "R4 rx value",
                {15'd0, rx_empty, rx_rd_data}, {16'd0, exp_rx});
            pop_rx();
        end
        chk(cs_n == 1'b1 && sck == 1'b0, "R5 R11 idle after record",
            {30'd0, cs_n, sck}, 32'd2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors += 1;
        checks += 1;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cs_n == 1'b1 && sck == 1'b0 && lane_oe == 4'h0 && busy == 1'b0 &&
            rx_empty == 1'b1 && tx_full == 1'b0, "R11 reset state",
            {24'd0, cs_n, sck, busy, rx_empty, lane_oe}, {24'd0, 8'b10010000});

        // sweep of every record option
        for (int iw = 0; iw < 3; iw++)
            for (int wd = 0; wd < 2; wd++)
                for (int oe = 0; oe < 2; oe++)
                    for (int np = 0; np < 2; np++) begin
                        logic [15:0] d;
                        d = 16'hA5C3 ^ 16'((iw * 8 + wd * 4 + oe * 2 + np) * 16'h1357);
                        run_record(np[0], oe[0], wd[0], iw[1:0], d);
                    end

        // R9 stall on full receive FIFO
        cur_w = 2'd0; cur_oe = 1'b0; cap = '0; cap_n = 0; oe_err = 0;
        push_rec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0011);
        push_rec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0022);
        push_rec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0033);
        repeat (300) @(negedge clk);
        chk(busy == 1'b1 && sck == 1'b0 && cap_n == 16, "R9 stalled with full RX",
            {busy, sck, 30'(cap_n)}, {2'b10, 30'd16});
        chk(rx_rd_data == 16'h00EE, "R9 first entry kept", rx_rd_data, 16'h00EE);
        pop_rx();
        wait (busy == 1'b0);
        @(negedge clk);
        chk(cap_n == 24, "R9 resumed after read", cap_n, 24);
        chk(rx_rd_data == 16'h00DD, "R9 second entry", rx_rd_data, 16'h00DD);
        pop_rx();
        chk(rx_rd_data == 16'h00CC && !rx_empty, "R9 third entry", rx_rd_data, 16'h00CC);
        pop_rx();
        chk(rx_empty == 1'b1, "R9 drained", {31'd0, rx_empty}, 32'd1);

        // R10 no-push record passes a full receive FIFO
        cap = '0; cap_n = 0;
        push_rec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0044);
        push_rec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0055);
        wait (busy == 1'b1);
        wait (busy == 1'b0);
        push_rec(1'b1, 1'b0, 1'b0, 2'd0, 16'h0066);
        wait (busy == 1'b1);
        wait (busy == 1'b0);
        @(negedge clk);
        chk(cap_n == 24 && cap[7:0] == 8'h66, "R10 no-push ran with RX full",
            {cap_n[15:0], cap}, {16'd24, 16'h5566});
        chk(rx_rd_data == 16'h00BB, "R10 RX contents untouched", rx_rd_data, 16'h00BB);
        pop_rx();
        chk(rx_rd_data == 16'h00AA && !rx_empty, "R10 second entry", rx_rd_data, 16'h00AA);
        pop_rx();
        chk(oe_err == 0, "R6 lane enables in stall tests", oe_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule